// File: doc/BRIEF.md
# Boot Memory Remap Selector

This block decides which physical memory answers bus accesses in the low address window that starts at zero. A three-bit mode register picks one of four targets: main flash, system flash, embedded SRAM or the external memory bank. The register does not reset to a constant. While reset is held it copies a value derived from the boot pin and the boot option bit. Once reset is released, software can overwrite it at any time and so alias a different memory at zero.

Each bus access presents an address with a request strobe. One clock later the block returns a region code, a translated offset inside that region, and a flag that says whether the access fell in the alias window. Addresses above the window bypass the mode and decode through a fixed native map. The block only decodes and steers. The memories, the fabric and the external bank timing sit outside it.

Top module: `boot_remap_top`

## Requirements
- R1: While `rst_n` is low the mode register loads 000 when `boot_pin`=0, 001 when `boot_pin`=1 and `boot_opt`=0, and 011 when `boot_pin`=1 and `boot_opt`=1. After reset is released, changes on the boot inputs leave the mode unchanged.
- R2: A read at register byte offset 0 returns the mode in `reg_rdata[2:0]`, with bits 31:3 reading as zero.
- R3: A write at offset 0 stores `reg_wdata[2:0]` into the mode. A write at any other offset changes nothing, and every other offset reads as zero.
- R4: An access with address bits 31:28 equal to zero is aliased. Mode 000 or 010 gives main flash, 001 gives system flash, 011 gives SRAM, and 1xx gives the external bank. Region codes are 0 none, 1 main flash, 2 system flash, 3 SRAM, 4 external bank. `acc_alias` is 1 for these accesses.
- R5: An aliased access to the external bank reaches only its first two banks (2^26 bytes each). The offset is address bits 26:0 with bit 27 cleared. Every other access carries address bits 27:0 as its offset.
- R6: Outside the window the mode is ignored and `acc_alias` is 0. Address bits 31:28 of 1 decode to main flash, 2 to system flash, 3 to SRAM and 6 to the external bank. Any other value gives region 0.
- R7: An access sampled with `acc_req`=1 at a clock edge appears on the outputs with `acc_valid`=1 after that edge. `acc_valid` is 0 after an edge with no request.
- R8: An access presented in the same cycle as a mode write uses the old mode. The next access uses the new one.
- R9: After a reset edge `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_pin | input | 1 | Boot-mode pin sampled during reset |
| boot_opt | input | 1 | Boot option bit sampled during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_req | input | 1 | Bus access strobe |
| acc_addr | input | 32 | Bus access address |
| acc_valid | output | 1 | Decoded result valid |
| acc_region | output | 3 | Target region code |
| acc_offset | output | 28 | Offset within the target region |
| acc_alias | output | 1 | Access hit the alias window |

## Verification
The hardest case to produce is the race between a mode write and an access in the same cycle. The bench drives the write and the request on the same falling edge, then checks that the result carries the old mapping and that the next access carries the new one. The boot-sampled reset value can only be reached by reset, so the bench resets once for each of the four pin combinations. It also toggles the pins after reset is released. Every one of the eight modes is then crossed with all sixteen address nibbles and with offsets that have bit 27 set and clear.

// File: rtl/boot_remap_pkg.sv
// Shared types and helpers for the boot remap selector.
// Assumes a 3-bit mode field and five region codes.
package boot_remap_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_MAIN = 3'd1,
        RGN_SYS  = 3'd2,
        RGN_SRAM = 3'd3,
        RGN_EXT  = 3'd4
    } region_t;

    // Maps the boot pin / option pair onto a mode encoding.
    function automatic logic [MODE_W-1:0] boot_to_mode(input logic pin, input logic opt);
        if (!pin)
            return 3'b000;
        else if (!opt)
            return 3'b001;
        else
            return 3'b011;
    endfunction

endpackage

// File: rtl/remap_mode_reg.sv
// Holds the remap mode. While reset is low it follows the boot inputs;
// after reset only a register write at offset zero changes it.
// Assumes byte offsets on reg_addr and a zero-extended read.
module remap_mode_reg
    import boot_remap_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic              boot_opt,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [MODE_W-1:0] mode_q
);

    logic sel_mode;
    logic unused_wdata;

    assign sel_mode     = (reg_addr == '0);
    assign unused_wdata = ^reg_wdata[REG_DW-1:MODE_W];

    // Mode storage: boot value under reset, software value afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= boot_to_mode(boot_pin, boot_opt);
        else if (reg_wr && sel_mode)
            mode_q <= reg_wdata[MODE_W-1:0];
    end

    // Read mux: mode at offset zero, zero everywhere else.
    always_comb begin
        reg_rdata = '0;
        if (sel_mode)
            reg_rdata[MODE_W-1:0] = mode_q;
    end

endmodule

// File: rtl/remap_decode.sv
// Combinational address decoder. Addresses in the low window follow the
// mode; the rest use a fixed native map keyed on the top address bits.
// Assumes the window is 2**WIN_BITS bytes and two external banks of
// 2**BANK_BITS bytes each can be aliased.
module remap_decode
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BITS  = 28,
    parameter int BANK_BITS = 26,
    parameter int NAT_MAIN  = 1,
    parameter int NAT_SYS   = 2,
    parameter int NAT_SRAM  = 3,
    parameter int NAT_EXT   = 6
) (
    input  logic [MODE_W-1:0]   mode,
    input  logic [ADDR_W-1:0]   addr,
    output region_t             region,
    output logic [WIN_BITS-1:0] offset,
    output logic                in_alias
);

    localparam int TAG_W   = ADDR_W - WIN_BITS;
    localparam int EXT_AW  = BANK_BITS + 1;

    logic [TAG_W-1:0] tag;
    region_t          alias_rgn;
    region_t          native_rgn;

    assign tag      = addr[ADDR_W-1:WIN_BITS];
    assign in_alias = (tag == '0);

    // Alias target chosen by the mode; the unused 010 falls back to main flash.
    always_comb begin
        if (mode[MODE_W-1])
            alias_rgn = RGN_EXT;
        else if (mode[1:0] == 2'b01)
            alias_rgn = RGN_SYS;
        else if (mode[1:0] == 2'b11)
            alias_rgn = RGN_SRAM;
        else
            alias_rgn = RGN_MAIN;
    end

    // Native map used above the alias window.
    always_comb begin
        if (tag == TAG_W'(NAT_MAIN))
            native_rgn = RGN_MAIN;
        else if (tag == TAG_W'(NAT_SYS))
            native_rgn = RGN_SYS;
        else if (tag == TAG_W'(NAT_SRAM))
            native_rgn = RGN_SRAM;
        else if (tag == TAG_W'(NAT_EXT))
            native_rgn = RGN_EXT;
        else
            native_rgn = RGN_NONE;
    end

    // Region and offset select; aliased external accesses see two banks only.
    generate
        if (EXT_AW < WIN_BITS) begin : g_ext_clip
            always_comb begin
                region = in_alias ? alias_rgn : native_rgn;
                offset = addr[WIN_BITS-1:0];
                if (in_alias && alias_rgn == RGN_EXT)
                    offset = {{(WIN_BITS-EXT_AW){1'b0}}, addr[EXT_AW-1:0]};
            end
        end else begin : g_ext_full
            always_comb begin
                region = in_alias ? alias_rgn : native_rgn;
                offset = addr[WIN_BITS-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/boot_remap_top.sv
// Top of the boot remap selector: mode register, decoder and a one-stage
// result register. An access sampled at an edge uses the mode held before
// that edge, so a write in the same cycle affects only later accesses.
module boot_remap_top
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BITS  = 28,
    parameter int BANK_BITS = 26,
    parameter int REG_AW    = 8,
    parameter int REG_DW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boot_pin,
    input  logic                boot_opt,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic                acc_req,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                acc_valid,
    output logic [2:0]          acc_region,
    output logic [WIN_BITS-1:0] acc_offset,
    output logic                acc_alias
);

    logic [MODE_W-1:0]   mode_q;
    region_t             dec_region;
    logic [WIN_BITS-1:0] dec_offset;
    logic                dec_alias;

    remap_mode_reg #(
        .REG_AW (REG_AW),
        .REG_DW (REG_DW)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_pin  (boot_pin),
        .boot_opt  (boot_opt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mode_q    (mode_q)
    );

    remap_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WIN_BITS),
        .BANK_BITS (BANK_BITS)
    ) u_dec (
        .mode     (mode_q),
        .addr     (acc_addr),
        .region   (dec_region),
        .offset   (dec_offset),
        .in_alias (dec_alias)
    );

    // Result stage: captures the decode of each requested access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid  <= 1'b0;
            acc_region <= RGN_NONE;
            acc_offset <= '0;
            acc_alias  <= 1'b0;
        end else begin
            acc_valid <= acc_req;
            if (acc_req) begin
                acc_region <= dec_region;
                acc_offset <= dec_offset;
                acc_alias  <= dec_alias;
            end
        end
    end

endmodule

// File: rtl/boot_remap_chk.sv
// Property checker for boot_remap_top, attached by bind below.
module boot_remap_chk
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BITS  = 28,
    parameter int BANK_BITS = 26,
    parameter int REG_AW    = 8,
    parameter int REG_DW    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [REG_DW-1:0]   reg_wdata,
    input logic [MODE_W-1:0]   mode_q,
    input logic                acc_req,
    input logic [ADDR_W-1:0]   acc_addr,
    input logic                acc_valid,
    input logic [2:0]          acc_region,
    input logic [WIN_BITS-1:0] acc_offset,
    input logic                acc_alias
);

    logic seen_edge;
    logic rst_prev;

    // Tracks the reset level of the previous edge for the idle check.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= rst_n;
        if (seen_edge === 1'b1 && rst_prev === 1'b0)
            p_idle_after_reset_r9: assert (acc_valid == 1'b0);
    end

    p_write_stores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0) |=> (mode_q == $past(reg_wdata[MODE_W-1:0])));

    p_mode_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == '0) |=> $stable(mode_q));

    p_valid_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> acc_valid);

    p_idle_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !acc_valid);

    p_ext_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_addr[ADDR_W-1:WIN_BITS] == '0 && mode_q[MODE_W-1])
        |=> (acc_region == RGN_EXT && acc_alias));

    p_two_banks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_alias && acc_region == RGN_EXT)
        |-> (acc_offset[WIN_BITS-1:BANK_BITS+1] == '0));

endmodule

bind boot_remap_top boot_remap_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .BANK_BITS (BANK_BITS),
    .REG_AW    (REG_AW),
    .REG_DW    (REG_DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .mode_q     (mode_q),
    .acc_req    (acc_req),
    .acc_addr   (acc_addr),
    .acc_valid  (acc_valid),
    .acc_region (acc_region),
    .acc_offset (acc_offset),
    .acc_alias  (acc_alias)
);

// File: tb/tb_boot_remap_top.sv
`timescale 1ns/1ps
module tb_boot_remap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_pin = 1'b0;
    logic        boot_opt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_req = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_valid;
    logic [2:0]  acc_region;
    logic [27:0] acc_offset;
    logic        acc_alias;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #4 clk = ~clk;

    boot_remap_top dut (
        .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .boot_opt(boot_opt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_valid(acc_valid), .acc_region(acc_region),
        .acc_offset(acc_offset), .acc_alias(acc_alias)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_region(input logic [2:0] m, input logic [31:0] a);
        if (a[31:28] == 4'h0) begin
            if (m[2]) return 3'd4;
            if (m == 3'b001) return 3'd2;
            if (m == 3'b011) return 3'd3;
            return 3'd1;
        end
        case (a[31:28])
            4'h1: return 3'd1;
            4'h2: return 3'd2;
            4'h3: return 3'd3;
            4'h6: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [27:0] exp_offset(input logic [2:0] m, input logic [31:0] a);
        if (a[31:28] == 4'h0 && m[2]) return {1'b0, a[26:0]};
        return a[27:0];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] off, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic do_access(input logic [2:0] m, input logic [31:0] a);
        acc_req = 1'b1; acc_addr = a;
        tick();
        acc_req = 1'b0;
        chk("R7 valid", {31'b0, acc_valid}, 32'd1);
        chk(a[31:28] == 0 ? "R4 alias region" : "R6 native region",
            {29'b0, acc_region}, {29'b0, exp_region(m, a)});
        chk("R5 offset", {4'b0, acc_offset}, {4'b0, exp_offset(m, a)});
        chk("R6 alias flag", {31'b0, acc_alias}, {31'b0, a[31:28] == 4'h0});
    endtask

    initial begin
        @(negedge clk);
        // R1/R2/R9: boot-sampled reset value for every pin combination.
        for (int b = 0; b < 4; b++) begin
            logic [2:0] bm;
            rst_n = 1'b0; boot_pin = b[1]; boot_opt = b[0];
            bm = !b[1] ? 3'b000 : (!b[0] ? 3'b001 : 3'b011);
            acc_req = 1'b1;
            tick(); tick();
            acc_req = 1'b0;
            chk("R9 valid low in reset", {31'b0, acc_valid}, 32'd0);
            rst_n = 1'b1;
            reg_addr = 8'h00;
            #1 chk("R1 boot mode", reg_rdata, {29'b0, bm});
            boot_pin = ~boot_pin; boot_opt = ~boot_opt;
            tick(); tick();
            chk("R1 pins ignored after reset", reg_rdata, {29'b0, bm});
            chk("R7 idle", {31'b0, acc_valid}, 32'd0);
        end

        // R2/R3/R4/R5/R6: every mode against every address nibble.
        for (int m = 0; m < 8; m++) begin
            do_write(8'h00, 32'hFFFF_FFF8 | m);
            #1 chk("R2 readback zero-extended", reg_rdata, m);
            for (int n = 0; n < 16; n++) begin
                do_access(m[2:0], {n[3:0], 28'hC00_1234});
                do_access(m[2:0], {n[3:0], 28'h055_AA55});
            end
        end

        // R3: other offsets ignored on write and read zero.
        do_write(8'h00, 32'h1);
        do_write(8'h04, 32'h6);
        do_write(8'h80, 32'h7);
        reg_addr = 8'h00;
        #1 chk("R3 other-offset write ignored", reg_rdata, 32'h1);
        reg_addr = 8'h04;
        #1 chk("R3 other offset reads zero", reg_rdata, 32'h0);
        reg_addr = 8'h00;
        do_access(3'b001, 32'h0000_0100);

        // R8: access in the same cycle as a write keeps the old mapping.
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h4;
        acc_req = 1'b1; acc_addr = 32'h0800_0010;
        tick();
        reg_wr = 1'b0; acc_req = 1'b0;
        chk("R8 old mapping in flight", {29'b0, acc_region}, 32'd2);
        chk("R8 old offset in flight", {4'b0, acc_offset}, 32'h0800_0010);
        do_access(3'b100, 32'h0800_0010);
        chk("R8 new mapping next access", {29'b0, acc_region}, 32'd4);
        tick();
        chk("R7 valid drops without request", {31'b0, acc_valid}, 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule